// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the bookkeeping state for an eight-entry floating-point register stack. It does not hold the register data or do any arithmetic. Its state is a 3-bit top-of-stack pointer, one empty tag per physical register, a 16-bit status word and a 16-bit control word. An instruction sequencer issues one command per clock. The block turns each command into pointer, tag and status updates. It also maps a stack-relative register number onto a physical register index for the data path.

The control word is decoded into a rounding mode and a precision mode for the arithmetic units. Exceptions raised by those units come back to this block as a flag mask. The block records the flags and decides whether they are unmasked. A later wait command then turns a pending unmasked exception into either an internal fault request or an external error signal.

Top module: `fpstk_ctrl`

## Requirements
- R1: The push command (cmd 1) sets the top pointer to (top - 1) mod 8 and marks the new top register valid (tag_empty bit cleared).
- R2: The pop command (cmd 2) marks the current top register empty (tag_empty bit set), then sets the top pointer to (top + 1) mod 8.
- R3: phys_idx always equals (top + reg_sel) mod 8. The free command (cmd 3) sets the tag_empty bit of that physical register and changes nothing else.
- R4: status_word shows the stored status with bits 13:11 replaced by the current top pointer. Commands that do not touch the status (nop, cmd 0) leave it unchanged.
- R5: The raise command (cmd 10) ORs exc_flags into status bits 5:0. If any raised flag has its control-word bit (bits 5:0) at 0, the command also sets status bit 7 (summary) and bit 15 (busy).
- R6: Reset and the initialize command (cmd 6) clear the stored status and the top pointer, set the control word to 0x037F and mark all eight tags empty.
- R7: The clear-exceptions command (cmd 7) keeps only status bits 14:8, which is an AND with 0x7F00.
- R8: The increment-pointer command (cmd 4) and the decrement-pointer command (cmd 5) move the top pointer by +1 and -1 mod 8. Both clear status bits 14, 10, 9 and 8 (mask 0x4700) and leave the tags unchanged.
- R9: The compare command (cmd 11) replaces status bits 14, 10 and 8 (mask 0x4500) with a pattern chosen by cmp_res: 0 (less) gives 0x0100, 1 (equal) gives 0x4000, 2 (greater) gives 0x0000, 3 (unordered) gives 0x4500.
- R10: The load command (cmd 8) writes cmd_data into the control word. round_mode equals control bits 11:10: 0 is nearest-even, 1 is down, 2 is up, 3 is toward zero.
- R11: prec_mode is 0 (32-bit) when control bits 9:8 are 00, 1 (64-bit) when they are 10, and 2 (80-bit) otherwise.
- R12: A wait command (cmd 9) issued while status bit 7 is set pulses fault_req for one cycle when native_err_en is 1. It pulses ext_err for one cycle when native_err_en is 0.
- R13: A wait command issued while status bit 7 is clear pulses neither fault_req nor ext_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Command code, one per cycle (0 = none) |
| reg_sel | input | 3 | Stack-relative register number for free and for index mapping |
| cmd_data | input | 16 | New control word for the load command |
| exc_flags | input | 6 | Exception flag mask for the raise command |
| cmp_res | input | 2 | Compare outcome for the compare command |
| native_err_en | input | 1 | Selects an internal fault instead of the external error line |
| status_word | output | 16 | Stored status with the top pointer in bits 13:11 |
| ctrl_word | output | 16 | Current control word |
| tag_empty | output | 8 | Empty tag per physical register |
| phys_idx | output | 3 | Physical index of the register selected by reg_sel |
| round_mode | output | 2 | Decoded rounding mode |
| prec_mode | output | 2 | Decoded precision mode |
| fault_req | output | 1 | One-cycle internal fault request |
| ext_err | output | 1 | One-cycle external error pulse |

## Verification
The assertions assume that cmd only ever carries one of the twelve defined codes. They also assume that the exception mask and compare inputs are meaningful only in the cycle of their own command. The stimulus keeps to these rules: it draws each command from the defined range and fills all operand fields at random on every cycle. Initialization is rare in the random mix, so the pointer wraps and the tags fill up and drain. Directed sequences load control words with cleared mask bits, which lets unmasked exceptions, and the wait pulses that follow them, actually occur.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_FREE  = 4'd3,
    OP_INCP  = 4'd4,
    OP_DECP  = 4'd5,
    OP_INIT  = 4'd6,
    OP_CLEX  = 4'd7,
    OP_LDCW  = 4'd8,
    OP_WAIT  = 4'd9,
    OP_RAISE = 4'd10,
    OP_CMP   = 4'd11
  } fpstk_op_e;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_DOWN    = 2'd1,
    RND_UP      = 2'd2,
    RND_ZERO    = 2'd3
  } rnd_mode_e;

  typedef enum logic [1:0] {
    PRC_SINGLE = 2'd0,
    PRC_DOUBLE = 2'd1,
    PRC_EXT    = 2'd2
  } prc_mode_e;

  localparam logic [15:0] CW_RESET  = 16'h037F;
  localparam logic [15:0] SW_KEEP   = 16'h7F00;
  localparam logic [15:0] CC_ALL    = 16'h4700;
  localparam logic [15:0] CC_CMP    = 16'h4500;
  localparam int          SW_SUM    = 7;
  localparam int          SW_BUSY   = 15;

  // Condition code pattern for a compare outcome: lt, eq, gt, unordered
  function automatic logic [15:0] cmp_pattern(input logic [1:0] res);
    case (res)
      2'd0:    cmp_pattern = 16'h0100;
      2'd1:    cmp_pattern = 16'h4000;
      2'd2:    cmp_pattern = 16'h0000;
      default: cmp_pattern = 16'h4500;
    endcase
  endfunction

endpackage

// File: rtl/fpstk_tagptr.sv
module fpstk_tagptr #(
  parameter int NREG = 8,
  localparam int PW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_push,
  input  logic            do_pop,
  input  logic            do_free,
  input  logic            do_inc,
  input  logic            do_dec,
  input  logic            do_init,
  input  logic [PW-1:0]   sel,
  output logic [PW-1:0]   top,
  output logic [PW-1:0]   phys,
  output logic [NREG-1:0] empty
);

  logic [PW-1:0] top_q, top_nx, top_up, top_dn;
  logic          top_en;

  // NREG is a power of two, so plain wraparound gives the modulo
  always_comb begin
    top_up = top_q + 1'b1;
    top_dn = top_q - 1'b1;
    phys   = top_q + sel;
    top_en = do_init | do_push | do_pop | do_inc | do_dec;
    top_nx = top_q;
    if (do_init)               top_nx = '0;
    else if (do_push | do_dec) top_nx = top_dn;
    else if (do_pop | do_inc)  top_nx = top_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (top_en) top_q <= top_nx;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic mark_e, mark_v, tag_q;
    always_comb begin
      mark_e = do_init | (do_pop && top_q == PW'(g)) | (do_free && phys == PW'(g));
      mark_v = do_push && top_dn == PW'(g);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tag_q <= 1'b1;
      else if (mark_e | mark_v) tag_q <= mark_e;
    end
    assign empty[g] = tag_q;
  end

  assign top = top_q;

  assert_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (top_q == PW'($past(top_q) - 1'b1)) && !empty[top_q]);
  assert_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> empty[$past(top_q)] && (top_q == PW'($past(top_q) + 1'b1)));
  assert_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_free |=> empty[$past(phys)] && $stable(top_q));
  assert_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> (&empty) && top_q == '0);

endmodule

// File: rtl/fpstk_status.sv
module fpstk_status
  import fpstk_pkg::*;
#(
  parameter int EXC_W = 6,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_init,
  input  logic             do_clex,
  input  logic             do_step,
  input  logic             do_raise,
  input  logic             do_cmp,
  input  logic             do_wait,
  input  logic [EXC_W-1:0] exc_flags,
  input  logic [EXC_W-1:0] cw_mask,
  input  logic [1:0]       cmp_res,
  input  logic             native_en,
  input  logic [PW-1:0]    top,
  output logic [15:0]      sw_out,
  output logic             fault_req,
  output logic             ext_err
);

  logic [15:0] sw_q, sw_nx;
  logic        sw_en, unmasked, pend;
  logic        fault_q, ext_q;

  always_comb begin
    unmasked = |(exc_flags & ~cw_mask);
    sw_en    = do_init | do_clex | do_step | do_raise | do_cmp;
    sw_nx    = sw_q;
    if (do_init)       sw_nx = '0;
    else if (do_clex)  sw_nx = sw_q & SW_KEEP;
    else if (do_step)  sw_nx = sw_q & ~CC_ALL;
    else if (do_cmp)   sw_nx = (sw_q & ~CC_CMP) | cmp_pattern(cmp_res);
    else if (do_raise) begin
      sw_nx[EXC_W-1:0] = sw_q[EXC_W-1:0] | exc_flags;
      if (unmasked) begin
        sw_nx[SW_SUM]  = 1'b1;
        sw_nx[SW_BUSY] = 1'b1;
      end
    end
    pend = do_wait && sw_q[SW_SUM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_en) sw_q <= sw_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      fault_q <= pend && native_en;
      ext_q   <= pend && !native_en;
    end
  end

  assign sw_out    = {sw_q[15:14], top, sw_q[10:0]};
  assign fault_req = fault_q;
  assign ext_err   = ext_q;

  assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_raise && unmasked) |=> sw_out[SW_SUM] && sw_out[SW_BUSY]);
  assert_clex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_clex |=> sw_out[7:0] == 8'h00 && !sw_out[15]);
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> !sw_out[14] && sw_out[10:8] == 3'b000);
  assert_unord_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_cmp && cmp_res == 2'd3) |=> sw_out[14] && sw_out[10] && sw_out[8]);
  assert_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wait && sw_out[SW_SUM]) |=> (fault_req != ext_err));
  assert_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wait && !sw_out[SW_SUM]) |=> !fault_req && !ext_err);

endmodule

// File: rtl/fpstk_ctlword.sv
module fpstk_ctlword
  import fpstk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        do_init,
  input  logic        do_load,
  input  logic [15:0] data,
  output logic [15:0] cw,
  output rnd_mode_e   rnd,
  output prc_mode_e   prc
);

  logic [15:0] cw_q, cw_nx;
  logic        cw_en;

  always_comb begin
    cw_en = do_init | do_load;
    cw_nx = do_init ? CW_RESET : data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cw_q <= CW_RESET;
    else if (cw_en) cw_q <= cw_nx;
  end

  always_comb begin
    rnd = rnd_mode_e'(cw_q[11:10]);
    case (cw_q[9:8])
      2'b00:   prc = PRC_SINGLE;
      2'b10:   prc = PRC_DOUBLE;
      default: prc = PRC_EXT;
    endcase
  end

  assign cw = cw_q;

  assert_init_cw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> cw == CW_RESET);
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> cw == $past(data));

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int EXC_W = 6,
  localparam int PW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd,
  input  logic [PW-1:0]    reg_sel,
  input  logic [15:0]      cmd_data,
  input  logic [EXC_W-1:0] exc_flags,
  input  logic [1:0]       cmp_res,
  input  logic             native_err_en,
  output logic [15:0]      status_word,
  output logic [15:0]      ctrl_word,
  output logic [NREG-1:0]  tag_empty,
  output logic [PW-1:0]    phys_idx,
  output logic [1:0]       round_mode,
  output logic [1:0]       prec_mode,
  output logic             fault_req,
  output logic             ext_err
);

  fpstk_op_e     op;
  logic [PW-1:0] top;
  rnd_mode_e     rnd;
  prc_mode_e     prc;

  assign op = fpstk_op_e'(cmd);

  fpstk_tagptr #(.NREG(NREG)) u_tagptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_push (op == OP_PUSH),
    .do_pop  (op == OP_POP),
    .do_free (op == OP_FREE),
    .do_inc  (op == OP_INCP),
    .do_dec  (op == OP_DECP),
    .do_init (op == OP_INIT),
    .sel     (reg_sel),
    .top     (top),
    .phys    (phys_idx),
    .empty   (tag_empty)
  );

  fpstk_status #(.EXC_W(EXC_W), .PW(PW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_init   (op == OP_INIT),
    .do_clex   (op == OP_CLEX),
    .do_step   (op == OP_INCP || op == OP_DECP),
    .do_raise  (op == OP_RAISE),
    .do_cmp    (op == OP_CMP),
    .do_wait   (op == OP_WAIT),
    .exc_flags (exc_flags),
    .cw_mask   (ctrl_word[EXC_W-1:0]),
    .cmp_res   (cmp_res),
    .native_en (native_err_en),
    .top       (top),
    .sw_out    (status_word),
    .fault_req (fault_req),
    .ext_err   (ext_err)
  );

  fpstk_ctlword u_ctlword (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_init (op == OP_INIT),
    .do_load (op == OP_LDCW),
    .data    (cmd_data),
    .cw      (ctrl_word),
    .rnd     (rnd),
    .prc     (prc)
  );

  assign round_mode = rnd;
  assign prec_mode  = prc;

  assert_cmd_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd <= 4'd11);
  assert_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> $stable(status_word) && $stable(tag_empty));

endmodule

// File: tb/sim_fpstk_ctrl.sv
module sim_fpstk_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cmd;
  logic [2:0]  reg_sel;
  logic [15:0] cmd_data;
  logic [5:0]  exc_flags;
  logic [1:0]  cmp_res;
  logic        native_err_en;
  logic [15:0] status_word, ctrl_word;
  logic [7:0]  tag_empty;
  logic [2:0]  phys_idx;
  logic [1:0]  round_mode, prec_mode;
  logic        fault_req, ext_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [2:0]  m_top;
  logic [7:0]  m_emp;
  logic [15:0] m_sw, m_cw;
  logic        m_fault, m_ext;

  always #10 clk = ~clk;

  fpstk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .reg_sel(reg_sel), .cmd_data(cmd_data),
    .exc_flags(exc_flags), .cmp_res(cmp_res), .native_err_en(native_err_en),
    .status_word(status_word), .ctrl_word(ctrl_word), .tag_empty(tag_empty),
    .phys_idx(phys_idx), .round_mode(round_mode), .prec_mode(prec_mode),
    .fault_req(fault_req), .ext_err(ext_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmp(input logic [1:0] r);
    case (r)
      2'd0: exp_cmp = 16'h0100;
      2'd1: exp_cmp = 16'h4000;
      2'd2: exp_cmp = 16'h0000;
      default: exp_cmp = 16'h4500;
    endcase
  endfunction

  function automatic logic [1:0] exp_prc(input logic [15:0] cw);
    case (cw[9:8])
      2'b00: exp_prc = 2'd0;
      2'b10: exp_prc = 2'd1;
      default: exp_prc = 2'd2;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1: req_of = "R1 push";
      4'd2: req_of = "R2 pop";
      4'd3: req_of = "R3 free";
      4'd4, 4'd5: req_of = "R8 step";
      4'd6: req_of = "R6 init";
      4'd7: req_of = "R7 clex";
      4'd8: req_of = "R10 load";
      4'd9: req_of = "R12 wait";
      4'd10: req_of = "R5 raise";
      4'd11: req_of = "R9 compare";
      default: req_of = "R4 nop";
    endcase
  endfunction

  task automatic model_init();
    m_top = 3'd0; m_emp = 8'hFF; m_sw = 16'h0000; m_cw = 16'h037F;
    m_fault = 1'b0; m_ext = 1'b0;
  endtask

  task automatic model_step();
    logic pend;
    pend = (cmd == 4'd9) && m_sw[7];
    m_fault = pend && native_err_en;
    m_ext   = pend && !native_err_en;
    case (cmd)
      4'd1: begin m_top = m_top - 3'd1; m_emp[m_top] = 1'b0; end
      4'd2: begin m_emp[m_top] = 1'b1; m_top = m_top + 3'd1; end
      4'd3: m_emp[m_top + reg_sel] = 1'b1;
      4'd4: begin m_top = m_top + 3'd1; m_sw = m_sw & ~16'h4700; end
      4'd5: begin m_top = m_top - 3'd1; m_sw = m_sw & ~16'h4700; end
      4'd6: begin model_init(); m_fault = 1'b0; m_ext = 1'b0; end
      4'd7: m_sw = m_sw & 16'h7F00;
      4'd8: m_cw = cmd_data;
      4'd10: begin
        m_sw[5:0] = m_sw[5:0] | exc_flags;
        if ((exc_flags & ~m_cw[5:0]) != 6'd0) begin m_sw[7] = 1'b1; m_sw[15] = 1'b1; end
      end
      4'd11: m_sw = (m_sw & ~16'h4500) | exp_cmp(cmp_res);
      default: ;
    endcase
  endtask

  task automatic check_all(input string req);
    chk(req, status_word, {m_sw[15:14], m_top, m_sw[10:0]});
    chk(req, {8'h00, tag_empty}, {8'h00, m_emp});
    chk("R10 R6 control word", ctrl_word, m_cw);
    chk("R10 rounding", {14'd0, round_mode}, {14'd0, m_cw[11:10]});
    chk("R11 precision", {14'd0, prec_mode}, {14'd0, exp_prc(m_cw)});
    chk("R12 R13 fault", {15'd0, fault_req}, {15'd0, m_fault});
    chk("R12 R13 ext", {15'd0, ext_err}, {15'd0, m_ext});
    chk("R3 index", {13'd0, phys_idx}, {13'd0, 3'(m_top + reg_sel)});
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] sel, input logic [15:0] data,
                       input logic [5:0] fl, input logic [1:0] cr, input logic en);
    @(negedge clk);
    cmd = op; reg_sel = sel; cmd_data = data; exc_flags = fl; cmp_res = cr; native_err_en = en;
    model_step();
    @(posedge clk);
    #5;
    check_all(req_of(op));
  endtask

  initial begin : watchdog
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] op;
    void'($urandom(32'd4711));
    rst_n = 1'b0; cmd = 4'd0; reg_sel = 3'd0; cmd_data = 16'h0; exc_flags = 6'd0;
    cmp_res = 2'd0; native_err_en = 1'b0;
    model_init();
    repeat (3) @(posedge clk);
    #5;
    check_all("R6 R4 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: pointer wrap on push and pop
    issue(4'd1, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);   // R1 top 0 -> 7
    issue(4'd1, 3'd2, 16'h0, 6'd0, 2'd0, 1'b0);
    issue(4'd3, 3'd1, 16'h0, 6'd0, 2'd0, 1'b0);   // R3 free ST(1)
    issue(4'd2, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);   // R2
    issue(4'd2, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);   // R2 wrap 7 -> 0
    // Directed: mode decode
    issue(4'd8, 3'd0, 16'h0000, 6'd0, 2'd0, 1'b0); // R10 R11
    issue(4'd8, 3'd0, 16'h0E3F, 6'd0, 2'd0, 1'b0);
    issue(4'd8, 3'd0, 16'h0500, 6'd0, 2'd0, 1'b0);
    // Directed: exceptions and wait
    issue(4'd9, 3'd0, 16'h0, 6'd0, 2'd0, 1'b1);    // R13 no summary
    issue(4'd10, 3'd0, 16'h0, 6'h04, 2'd0, 1'b0);  // R5 unmasked
    issue(4'd9, 3'd0, 16'h0, 6'd0, 2'd0, 1'b1);    // R12 fault
    issue(4'd9, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);    // R12 ext
    for (int k = 0; k < 4; k++) issue(4'd11, 3'd0, 16'h0, 6'd0, 2'(k), 1'b0); // R9
    issue(4'd4, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);    // R8
    issue(4'd7, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);    // R7
    issue(4'd9, 3'd0, 16'h0, 6'd0, 2'd0, 1'b1);    // R13 after clear
    issue(4'd8, 3'd0, 16'h037F, 6'd0, 2'd0, 1'b0);
    issue(4'd10, 3'd0, 16'h0, 6'h3F, 2'd0, 1'b0);  // R5 all masked
    issue(4'd5, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);    // R8
    issue(4'd6, 3'd0, 16'h0, 6'd0, 2'd0, 1'b0);    // R6

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      op = 4'($urandom_range(0, 11));
      if (op == 4'd6 && $urandom_range(0, 15) != 0) op = 4'd1;
      if (op == 4'd8 && $urandom_range(0, 1) == 0) op = 4'd10;
      issue(op, 3'($urandom), 16'($urandom), 6'($urandom), 2'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule